// File: doc/BRIEF.md
# Hysteretic Buck Gate Sequencer

This block decides when the two power switches of a synchronous step-down converter conduct. It has no fixed PWM period. A conduction cycle opens only when the feedback comparator reports the output under its regulation threshold. The high-side pulse then lasts for at least a set number of clock cycles. It ends when the output is back in regulation, or at once when the high-side current limit trips.

After the high-side pulse, the low-side rectifier conducts. It carries on until the next high-side pulse is due or until the inductor current falls to the release level. Once released, the rectifier stays open for the rest of that cycle, which gives discontinuous conduction at light load. Every hand-over between the two gates passes through a dead-time gap. The next high-side pulse is held back until a minimum off-time has run.

All three comparator flags arrive asynchronously. Each passes through a two-stage synchroniser before the state machine uses it. The enable is taken as synchronous to the clock. Every port is a plain level signal, so no handshake applies at the edge of the block.

Top module: `hbuck_gate_ctrl`

## Requirements
- R1: While reset is held, and from the first clock edge that samples `enable` low, both gates are low and `sw_hiz` is high. With `enable` high and no cycle started, `sw_hiz` stays high.
- R2: Each comparator flag (active high) goes through a two-flop synchroniser. From rest, with `fb_below` raised between edges, `hs_gate` rises on the 5th rising edge, which is SYNC_STAGES + 1 + DEAD_CYC.
- R3: Unless the current limit trips, a high-side pulse lasts at least TON_CYC cycles. It continues while `fb_below` stays high. If `fb_below` is already low when the on-time expires, the pulse lasts exactly TON_CYC cycles.
- R4: A synchronised `hs_overcurrent` seen during the pulse drops `hs_gate` on the next edge, even before TON_CYC. Raised right after the gate rises, it gives a pulse of SYNC_STAGES + 1 cycles.
- R5: `hs_gate` stays low for at least TOFF_CYC cycles between pulses, and it rises only after `fb_below` has been seen high. With `fb_below` held high through the gap, the low time is exactly TOFF_CYC + DEAD_CYC cycles.
- R6: The two gates are never high together. Exactly DEAD_CYC cycles with both gates low separate one gate falling from the other rising.
- R7: A synchronised `il_low` releases `ls_gate`, and `sw_hiz` then goes high. `ls_gate` stays low, whatever `il_low` does next, until another high-side pulse has occurred. An `il_low` already high at the end of the dead time skips the low-side phase.
- R8: With `il_low` low and `fb_below` low, `ls_gate` stays high indefinitely after a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run enable, synchronous to clk |
| fb_below | input | 1 | Feedback comparator: output below threshold (async) |
| hs_overcurrent | input | 1 | High-side current limit tripped (async) |
| il_low | input | 1 | Inductor current below rectifier release level (async) |
| hs_gate | output | 1 | High-side switch enable |
| ls_gate | output | 1 | Low-side rectifier enable |
| sw_hiz | output | 1 | Switch node floating: at rest or rectifier released |

## Verification
A wrong phase register shows on the gate pins in the very next cycle. The bench model follows the phase every cycle, so a state slip is reported at the first clock after it. A timer that starts or clears on the wrong edge does not show at once. It moves a gate edge by one or more cycles, so it appears when the pulse ends, or when the off gap or dead time closes. This is why pulse widths, off gaps and dead gaps are measured at the pins and compared with exact counts. A synchroniser of the wrong depth moves every reaction to a flag by one cycle, and the start-latency and current-limit pulse-width checks catch that.

// File: rtl/hbk_pkg.sv
package hbk_pkg;
  typedef enum logic [2:0] {
    PH_REST   = 3'd0,
    PH_GAP_HS = 3'd1,
    PH_HS     = 3'd2,
    PH_GAP_LS = 3'd3,
    PH_LS     = 3'd4,
    PH_FLOAT  = 3'd5
  } phase_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/hbk_sync.sv
module hbk_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/hbk_count.sv
module hbk_count #(
  parameter int W     = 4,
  parameter int LIMIT = 15,
  parameter int INIT  = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] LIM_V  = W'(LIMIT);
  localparam logic [W-1:0] INIT_V = W'(INIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           q <= INIT_V;
    else if (clr)         q <= '0;
    else if (q != LIM_V)  q <= q + 1'b1;
  end
endmodule

// File: rtl/hbk_fsm.sv
module hbk_fsm
  import hbk_pkg::*;
#(
  parameter int DEAD_CYC = 2,
  parameter int TON_CYC  = 10,
  parameter int TOFF_CYC = 10,
  parameter int PH_W     = 4,
  parameter int OFF_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             fb_low,
  input  logic             oc,
  input  logic             iz,
  input  logic [PH_W-1:0]  ph_cnt,
  input  logic [OFF_W-1:0] off_cnt,
  output logic             ph_clr,
  output logic             off_clr,
  output logic             hs_on,
  output logic             ls_on,
  output logic             node_float
);
  localparam logic [PH_W-1:0]  DEAD_LAST = PH_W'(DEAD_CYC - 1);
  localparam logic [PH_W-1:0]  ON_LAST   = PH_W'(TON_CYC - 1);
  localparam logic [OFF_W-1:0] OFF_LAST  = OFF_W'(TOFF_CYC - 1);

  phase_e st, st_nx;
  logic   gap_done, on_done, restart;

  assign gap_done = (ph_cnt >= DEAD_LAST);
  assign on_done  = (ph_cnt >= ON_LAST);
  assign restart  = (off_cnt >= OFF_LAST) && fb_low;

  always_comb begin
    st_nx = st;
    if (!enable) begin
      st_nx = PH_REST;
    end else begin
      case (st)
        PH_REST:   if (restart) st_nx = PH_GAP_HS;
        PH_GAP_HS: if (gap_done) st_nx = PH_HS;
        PH_HS:     if (oc || (on_done && !fb_low)) st_nx = PH_GAP_LS;
        PH_GAP_LS: if (gap_done) st_nx = iz ? PH_FLOAT : PH_LS;
        PH_LS:     if (restart) st_nx = PH_GAP_HS;
                   else if (iz) st_nx = PH_FLOAT;
        PH_FLOAT:  if (restart) st_nx = PH_GAP_HS;
        default:   st_nx = PH_REST;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= PH_REST;
    else        st <= st_nx;
  end

  assign ph_clr     = (st_nx != st);
  assign off_clr    = (st == PH_HS);
  assign hs_on      = (st == PH_HS);
  assign ls_on      = (st == PH_LS);
  assign node_float = (st == PH_REST) || (st == PH_FLOAT);
endmodule

// File: rtl/hbuck_gate_ctrl.sv
module hbuck_gate_ctrl
  import hbk_pkg::*;
#(
  parameter int DEAD_CYC    = 2,
  parameter int TON_CYC     = 10,
  parameter int TOFF_CYC    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic fb_below,
  input  logic hs_overcurrent,
  input  logic il_low,
  output logic hs_gate,
  output logic ls_gate,
  output logic sw_hiz
);
  localparam int PH_LIM = int'(max2(TON_CYC, DEAD_CYC));
  localparam int PH_W   = $clog2(PH_LIM + 1);
  localparam int OFF_W  = $clog2(TOFF_CYC + 1);

  logic [2:0]       flags_s;
  logic             fb_s, oc_s, iz_s;
  logic             ph_clr, off_clr;
  logic [PH_W-1:0]  ph_cnt;
  logic [OFF_W-1:0] off_cnt;

  hbk_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({il_low, hs_overcurrent, fb_below}),
    .q     (flags_s)
  );
  assign {iz_s, oc_s, fb_s} = flags_s;

  // phase timer: dead-time and on-time, restarts on every phase change
  hbk_count #(.W(PH_W), .LIMIT(PH_LIM), .INIT(0)) u_ph_cnt (
    .clk (clk), .rst_n (rst_n), .clr (ph_clr), .q (ph_cnt)
  );

  // off timer: cycles since the high side last conducted; starts satisfied
  hbk_count #(.W(OFF_W), .LIMIT(TOFF_CYC), .INIT(TOFF_CYC)) u_off_cnt (
    .clk (clk), .rst_n (rst_n), .clr (off_clr), .q (off_cnt)
  );

  hbk_fsm #(
    .DEAD_CYC (DEAD_CYC), .TON_CYC (TON_CYC), .TOFF_CYC (TOFF_CYC),
    .PH_W     (PH_W),     .OFF_W   (OFF_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .fb_low     (fb_s),
    .oc         (oc_s),
    .iz         (iz_s),
    .ph_cnt     (ph_cnt),
    .off_cnt    (off_cnt),
    .ph_clr     (ph_clr),
    .off_clr    (off_clr),
    .hs_on      (hs_gate),
    .ls_on      (ls_gate),
    .node_float (sw_hiz)
  );
endmodule

// File: rtl/hbk_checker.sv
module hbk_checker #(
  parameter int DEAD_CYC = 2,
  parameter int TON_CYC  = 10,
  parameter int TOFF_CYC = 10
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic hs,
  input logic ls,
  input logic hiz,
  input logic oc_s
);
  int   gap_run, on_run, off_run;
  logic hs_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_run <= 0;
      on_run  <= 0;
      off_run <= TOFF_CYC;
      hs_seen <= 1'b0;
    end else begin
      gap_run <= (hs || ls) ? 0 : ((gap_run < DEAD_CYC) ? gap_run + 1 : gap_run);
      on_run  <= !hs ? 0 : ((on_run < TON_CYC) ? on_run + 1 : on_run);
      off_run <= hs ? 0 : ((off_run < TOFF_CYC) ? off_run + 1 : off_run);
      hs_seen <= hs ? 1'b1 : (ls ? 1'b0 : hs_seen);
    end
  end

  assert_gates_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs && ls));

  assert_deadtime_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hs) || $rose(ls)) |-> (gap_run >= DEAD_CYC));

  assert_disable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (hiz && !hs && !ls));

  assert_ocp_cut_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && oc_s) |=> !hs);

  assert_min_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hs) && !$past(oc_s) && $past(enable)) |-> (on_run >= TON_CYC));

  assert_min_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs) |-> (off_run >= TOFF_CYC));

  assert_relatch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls) |-> hs_seen);
endmodule

bind hbuck_gate_ctrl hbk_checker #(
  .DEAD_CYC (DEAD_CYC), .TON_CYC (TON_CYC), .TOFF_CYC (TOFF_CYC)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .enable (enable),
  .hs     (hs_gate),
  .ls     (ls_gate),
  .hiz    (sw_hiz),
  .oc_s   (oc_s)
);

// File: tb/tb_hbuck_gate_ctrl.sv
`timescale 1ns/1ps
module tb_hbuck_gate_ctrl;
  localparam int DEAD = 2;
  localparam int TON  = 10;
  localparam int TOFF = 10;
  localparam int SYNC = 2;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, fb = 1'b0, oc = 1'b0, iz = 1'b0;
  logic hs, ls, hiz;
  int   total = 0, bad = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  hbuck_gate_ctrl #(.DEAD_CYC(DEAD), .TON_CYC(TON), .TOFF_CYC(TOFF), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst_n(rst_n), .enable(en), .fb_below(fb), .hs_overcurrent(oc),
    .il_low(iz), .hs_gate(hs), .ls_gate(ls), .sw_hiz(hiz)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference: mode 0 rest, 1 gap before high, 2 high, 3 gap before low, 4 low, 5 floating
  int m_mode = 0, m_t = 0, m_off = TOFF, nm;
  int dly_fb[$], dly_oc[$], dly_iz[$];
  logic mf, mo, mz;
  initial begin
    for (int i = 0; i < SYNC; i++) begin dly_fb.push_back(0); dly_oc.push_back(0); dly_iz.push_back(0); end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_t = 0; m_off = TOFF;
      foreach (dly_fb[i]) begin dly_fb[i] = 0; dly_oc[i] = 0; dly_iz[i] = 0; end
    end else begin
      mf = dly_fb[0]; mo = dly_oc[0]; mz = dly_iz[0];
      nm = m_mode;
      if (!en) nm = 0;
      else if ((m_mode == 0 || m_mode == 4 || m_mode == 5) && m_off >= TOFF - 1 && mf) nm = 1;
      else if (m_mode == 1 && m_t >= DEAD - 1) nm = 2;
      else if (m_mode == 2 && (mo || (m_t >= TON - 1 && !mf))) nm = 3;
      else if (m_mode == 3 && m_t >= DEAD - 1) nm = mz ? 5 : 4;
      else if (m_mode == 4 && mz) nm = 5;
      if (m_mode == 2) m_off = 0; else if (m_off < TOFF) m_off++;
      if (nm != m_mode) m_t = 0; else if (m_t < 1000) m_t++;
      m_mode = nm;
      void'(dly_fb.pop_front()); dly_fb.push_back(int'(fb));
      void'(dly_oc.pop_front()); dly_oc.push_back(int'(oc));
      void'(dly_iz.pop_front()); dly_iz.push_back(int'(iz));
    end
  end

  // pin measurements and per-cycle comparison
  int hs_run = 0, lo_run = 0, last_w = 0, last_lo = 0, gap_run = 0, last_gap = 0;
  logic hs_p = 1'b0, ls_p = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R3 hs_gate vs model", int'(hs), int'(m_mode == 2));
      check("R8 ls_gate vs model", int'(ls), int'(m_mode == 4));
      check("R1 sw_hiz vs model", int'(hiz), int'(m_mode == 0 || m_mode == 5));
      check("R6 gates exclusive", int'(hs && ls), 0);
      if (hs) begin
        if (!hs_p) last_lo = lo_run;
        hs_run++; lo_run = 0;
      end else begin
        if (hs_p) last_w = hs_run;
        hs_run = 0; lo_run++;
      end
      if (hs || ls) begin
        if (!(hs_p || ls_p)) last_gap = gap_run;
        gap_run = 0;
      end else gap_run++;
      hs_p = hs; ls_p = ls;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask
  task automatic wait_hs(input logic v);
    for (int g = 0; g < 500 && hs !== v; g++) cyc(1);
  endtask
  task automatic wait_ls(input logic v);
    for (int g = 0; g < 500 && ls !== v; g++) cyc(1);
  endtask

  initial begin
    int k;
    cyc(3);
    check("R1 reset hs_gate", int'(hs), 0);
    check("R1 reset ls_gate", int'(ls), 0);
    check("R1 reset sw_hiz", int'(hiz), 1);
    rst_n = 1'b1; en = 1'b1;
    cyc(8);
    check("R5 no start without fb_below", int'(hs), 0);
    check("R1 hiz before first cycle", int'(hiz), 1);

    fb = 1'b1; k = 0;
    while (hs !== 1'b1 && k < 50) begin @(posedge clk); #1; k++; end
    check("R2 start latency", k, SYNC + 1 + DEAD);
    cyc(TON + 3);
    check("R3 pulse held while below", int'(hs), 1);
    fb = 1'b0;
    wait_hs(1'b0);
    check("R3 long pulse at least TON", int'(last_w > TON), 1);
    wait_ls(1'b1);
    check("R6 gap high to low", last_gap, DEAD);
    cyc(30);
    check("R8 rectifier holds", int'(ls), 1);
    check("R8 node driven", int'(hiz), 0);

    iz = 1'b1; cyc(SYNC + 3);
    check("R7 rectifier released", int'(ls), 0);
    check("R7 node floats", int'(hiz), 1);
    iz = 1'b0; cyc(12);
    check("R7 rectifier stays released", int'(ls), 0);

    fb = 1'b1; wait_hs(1'b1); fb = 1'b0; wait_hs(1'b0);
    check("R3 exact minimum pulse", last_w, TON);
    wait_ls(1'b1);
    check("R6 gap after min pulse", last_gap, DEAD);
    fb = 1'b1; wait_hs(1'b1);
    check("R5 off interval", last_lo, TOFF + DEAD);
    check("R6 gap low to high", last_gap, DEAD);
    fb = 1'b0; wait_hs(1'b0); cyc(3);

    fb = 1'b1; wait_hs(1'b1); oc = 1'b1; wait_hs(1'b0);
    check("R4 current limit pulse", last_w, SYNC + 1);
    check("R4 cut before TON", int'(last_w < TON), 1);
    oc = 1'b0; fb = 1'b0; cyc(TOFF + 5);

    fb = 1'b1; wait_hs(1'b1); en = 1'b0; cyc(1);
    check("R1 disable hs_gate", int'(hs), 0);
    check("R1 disable ls_gate", int'(ls), 0);
    check("R1 disable sw_hiz", int'(hiz), 1);
    cyc(5); fb = 1'b0; en = 1'b1; cyc(5);
    check("R1 rest after re-enable", int'(hiz), 1);

    for (int i = 0; i < 1500; i++) begin
      en = ($urandom_range(0, 40) != 0);
      fb = ($urandom_range(0, 2) == 0);
      oc = ($urandom_range(0, 7) == 0);
      iz = ($urandom_range(0, 3) == 0);
      cyc(1 + $urandom_range(0, 6));
    end
    cyc(2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule